// File: doc/BRIEF.md
# DRAM DLL Control Command Sequencer

This block sits on the controller side of a graphics DRAM channel. It issues the mode-register commands that reset the memory's DLL, or that take the DLL through a clock-frequency change. It also enforces the quiet periods that must follow those commands. A request input starts each sequence. The block then drives a one-cycle command strobe with a two-bit command code and a 12-bit address that carries the mode-register bits. It holds `busy` high and `cmd_ok` low until the last wait period ends, and then pulses `done`.

The reset path works as follows. In `ST_IDLE`, a DLL-reset request moves the machine to `ST_RST_CMD`. That state issues a mode-register command with the reset bit (address bit 8) set. Next, `ST_PD_LOCK` holds off power-down for `PDN_LOCK` cycles, and the machine then returns to `ST_IDLE`.

The frequency-change path issues no DLL reset:
- `ST_DIS_CMD` sends an extended mode-register command with the DLL-enable bit cleared.
- `ST_WAIT_CLK` waits, with no timeout, until the `clk_stable` input is seen high.
- `ST_EN_CMD` sends the extended command with the DLL-enable bit set.
- `ST_LOCK_WAIT` blocks every command for `LOCK_CYC` cycles and then returns to `ST_IDLE`.

A power-down request in `ST_IDLE` passes through `ST_PD_CMD`, which issues the power-down strobe, and then returns to `ST_IDLE`. The block keeps shadow copies of the mode and extended-mode registers. A synchronous reset returns both shadows to their defaults.

Top module: `dll_cmd_seq`

## Requirements
- R1: Address bit 7 is 0 on every command strobe, whatever the configured mode defaults hold.
- R2: A DLL-reset request accepted in idle gives, on the next cycle, a strobe with code 1 (mode register). Its address is `MODE_INIT` with bit 8 forced to 1 and bit 7 forced to 0.
- R3: After the reset strobe, the mode shadow holds bit 8 at 0, so a later reset command again carries exactly the configured bits plus bit 8.
- R4: Let the reset strobe fall in cycle t. No power-down strobe appears in cycles t+1 to t+`PDN_LOCK`. With `pd_req` held high, the power-down strobe (code 3, address 0) appears in cycle t+`PDN_LOCK`+2.
- R5: A frequency-change request accepted in idle gives, on the next cycle, a strobe with code 2 (extended mode register) whose DLL-enable bit (`DLL_POS`) is 0. No strobe follows while `clk_stable` stays low. The cycle after `clk_stable` is sampled high gives a code-2 strobe with that bit at 1. No code-1 strobe is issued on this path.
- R6: Let the DLL-enable strobe fall in cycle t. Cycles t+1 to t+`LOCK_CYC` carry no strobe, with `busy` high and `cmd_ok` low. In cycle t+`LOCK_CYC`+1, `cmd_ok` is high.
- R7: Requests that arrive while `busy` is high are ignored and are not queued.
- R8: `cmd_ok` is the inverse of `busy`. `done` is high for exactly one cycle, in the cycle where `cmd_ok` returns high at the end of a reset or frequency-change sequence.
- R9: When requests arrive together, DLL reset wins over frequency change, and frequency change wins over power-down.
- R10: A power-down request in idle gives, on the next cycle, a code-3 strobe with address 0, followed by a return to idle without a `done` pulse.
- R11: A synchronous reset forces idle in the next cycle: `busy` low, `cmd_ok` high, `done` low, no strobe. It also returns both shadow registers to their defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_dll_rst | input | 1 | Start DLL reset sequence (sampled in idle) |
| req_freq_chg | input | 1 | Start frequency-change sequence (sampled in idle) |
| clk_stable | input | 1 | New clock has settled |
| pd_req | input | 1 | Request a power-down command |
| cmd_valid | output | 1 | Command strobe |
| cmd_code | output | 2 | 0 none, 1 mode register, 2 extended mode register, 3 power-down |
| cmd_addr | output | 12 | Mode-register bits for the command |
| busy | output | 1 | A sequence or command is in progress |
| cmd_ok | output | 1 | Other commands may be issued |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The assertions assume that `rst` is high at time zero and for at least one clock edge. They also assume `PDN_LOCK` and `LOCK_CYC` are at least 1. Request and `clk_stable` inputs are taken as synchronous to `clk`. The bench changes every input only on the falling edge, so each is stable at the sampling edge. It raises `clk_stable` only once the machine is waiting for it, after a random delay of at least one cycle. Stray requests are injected only while the machine is busy, and they are cleared before it returns to idle. This keeps their being ignored observable at the ports.

// File: rtl/dll_seq_pkg.sv
package dll_seq_pkg;

    localparam int ADDR_W   = 12;
    localparam int TEST_BIT = 7;
    localparam int RST_BIT  = 8;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_MRS  = 2'd1,
        CMD_EMRS = 2'd2,
        CMD_PDN  = 2'd3
    } cmd_code_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_CMD,
        ST_PD_LOCK,
        ST_PD_CMD,
        ST_DIS_CMD,
        ST_WAIT_CLK,
        ST_EN_CMD,
        ST_LOCK_WAIT
    } seq_state_t;

endpackage

// File: rtl/dll_wait_timer.sv
module dll_wait_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

    // R6: a decrement never starts from an empty count without a reload
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
        (dec && !load && zero) |=> zero);

endmodule

// File: rtl/dll_mode_shadow.sv
module dll_mode_shadow
    import dll_seq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] MODE_INIT  = 12'h052,
    parameter logic [ADDR_W-1:0] EMODE_INIT = 12'h040,
    parameter int                DLL_POS    = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_rst,
    input  logic              issue_dis,
    input  logic              issue_en,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] TEST_MASK = ADDR_W'(1) << TEST_BIT;
    localparam logic [ADDR_W-1:0] RST_MASK  = ADDR_W'(1) << RST_BIT;
    localparam logic [ADDR_W-1:0] DLL_MASK  = ADDR_W'(1) << DLL_POS;
    localparam logic [ADDR_W-1:0] MR_RESET  = MODE_INIT & ~(TEST_MASK | RST_MASK);

    logic [ADDR_W-1:0] mr_q;
    logic [ADDR_W-1:0] emr_q;
    logic [ADDR_W-1:0] raw_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            mr_q  <= MR_RESET;
            emr_q <= EMODE_INIT;
        end else begin
            if (issue_rst) begin
                mr_q <= mr_q & ~RST_MASK;
            end
            if (issue_dis) begin
                emr_q <= emr_q & ~DLL_MASK;
            end else if (issue_en) begin
                emr_q <= emr_q | DLL_MASK;
            end
        end
    end

    always_comb begin
        raw_addr = '0;
        if (issue_rst) begin
            raw_addr = mr_q | RST_MASK;
        end else if (issue_dis) begin
            raw_addr = emr_q & ~DLL_MASK;
        end else if (issue_en) begin
            raw_addr = emr_q | DLL_MASK;
        end
        addr = raw_addr & ~TEST_MASK;
    end

    // R3: the shadow drops the reset bit once the reset command has gone out
    assert_shadow_clear_R3: assert property (@(posedge clk) disable iff (rst)
        issue_rst |=> !mr_q[RST_BIT]);

    // R5: the enable command leaves the shadow with the DLL enabled
    assert_shadow_dll_on_R5: assert property (@(posedge clk) disable iff (rst)
        issue_en |=> emr_q[DLL_POS]);

endmodule

// File: rtl/dll_seq_fsm.sv
module dll_seq_fsm
    import dll_seq_pkg::*;
#(
    parameter int PDN_LOCK = 10,
    parameter int LOCK_CYC = 20000,
    parameter int CNT_W    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_dll_rst,
    input  logic             req_freq_chg,
    input  logic             clk_stable,
    input  logic             pd_req,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_load_val,
    output logic             tmr_dec,
    output logic             issue_rst,
    output logic             issue_dis,
    output logic             issue_en,
    output logic             cmd_valid,
    output cmd_code_t        cmd_code,
    output logic             busy,
    output logic             cmd_ok,
    output logic             done
);

    localparam logic [CNT_W-1:0] PDN_LOAD  = CNT_W'(PDN_LOCK - 1);
    localparam logic [CNT_W-1:0] LOCK_LOAD = CNT_W'(LOCK_CYC - 1);

    seq_state_t state_q;
    seq_state_t state_d;
    logic       done_q;
    logic       wait_end;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_dll_rst) begin
                    state_d = ST_RST_CMD;
                end else if (req_freq_chg) begin
                    state_d = ST_DIS_CMD;
                end else if (pd_req) begin
                    state_d = ST_PD_CMD;
                end
            end
            ST_RST_CMD:   state_d = ST_PD_LOCK;
            ST_PD_LOCK:   if (tmr_zero) state_d = ST_IDLE;
            ST_PD_CMD:    state_d = ST_IDLE;
            ST_DIS_CMD:   state_d = ST_WAIT_CLK;
            ST_WAIT_CLK:  if (clk_stable) state_d = ST_EN_CMD;
            ST_EN_CMD:    state_d = ST_LOCK_WAIT;
            ST_LOCK_WAIT: if (tmr_zero) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    assign wait_end = tmr_zero && ((state_q == ST_PD_LOCK) || (state_q == ST_LOCK_WAIT));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= wait_end;
        end
    end

    always_comb begin
        tmr_load     = 1'b0;
        tmr_load_val = '0;
        tmr_dec      = 1'b0;
        issue_rst    = 1'b0;
        issue_dis    = 1'b0;
        issue_en     = 1'b0;
        cmd_valid    = 1'b0;
        cmd_code     = CMD_NONE;
        busy         = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
            end
            ST_RST_CMD: begin
                issue_rst    = 1'b1;
                cmd_valid    = 1'b1;
                cmd_code     = CMD_MRS;
                tmr_load     = 1'b1;
                tmr_load_val = PDN_LOAD;
            end
            ST_PD_LOCK: begin
                tmr_dec = 1'b1;
            end
            ST_PD_CMD: begin
                cmd_valid = 1'b1;
                cmd_code  = CMD_PDN;
            end
            ST_DIS_CMD: begin
                issue_dis = 1'b1;
                cmd_valid = 1'b1;
                cmd_code  = CMD_EMRS;
            end
            ST_WAIT_CLK: begin
            end
            ST_EN_CMD: begin
                issue_en     = 1'b1;
                cmd_valid    = 1'b1;
                cmd_code     = CMD_EMRS;
                tmr_load     = 1'b1;
                tmr_load_val = LOCK_LOAD;
            end
            ST_LOCK_WAIT: begin
                tmr_dec = 1'b1;
            end
            default: begin
            end
        endcase
        cmd_ok = !busy;
        done   = done_q;
    end

    // R7: a request seen while busy never restarts a command in the next cycle
    assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && !cmd_valid && !wait_end && state_q != ST_WAIT_CLK) |=> !cmd_valid);

    // R5: leaving the clock wait needs the stable input
    assert_wait_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT_CLK && !clk_stable) |=> (state_q == ST_WAIT_CLK));

endmodule

// File: rtl/dll_cmd_seq.sv
module dll_cmd_seq
    import dll_seq_pkg::*;
#(
    parameter int                PDN_LOCK   = 10,
    parameter int                LOCK_CYC   = 20000,
    parameter int                DLL_POS    = 6,
    parameter logic [11:0]       MODE_INIT  = 12'h052,
    parameter logic [11:0]       EMODE_INIT = 12'h040
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_dll_rst,
    input  logic        req_freq_chg,
    input  logic        clk_stable,
    input  logic        pd_req,
    output logic        cmd_valid,
    output logic [1:0]  cmd_code,
    output logic [11:0] cmd_addr,
    output logic        busy,
    output logic        cmd_ok,
    output logic        done
);

    localparam int MAX_WAIT = (PDN_LOCK > LOCK_CYC) ? PDN_LOCK : LOCK_CYC;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);

    logic             tmr_zero;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_load_val;
    logic             tmr_dec;
    logic             issue_rst;
    logic             issue_dis;
    logic             issue_en;
    cmd_code_t        code_e;

    dll_seq_fsm #(
        .PDN_LOCK (PDN_LOCK),
        .LOCK_CYC (LOCK_CYC),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .req_dll_rst  (req_dll_rst),
        .req_freq_chg (req_freq_chg),
        .clk_stable   (clk_stable),
        .pd_req       (pd_req),
        .tmr_zero     (tmr_zero),
        .tmr_load     (tmr_load),
        .tmr_load_val (tmr_load_val),
        .tmr_dec      (tmr_dec),
        .issue_rst    (issue_rst),
        .issue_dis    (issue_dis),
        .issue_en     (issue_en),
        .cmd_valid    (cmd_valid),
        .cmd_code     (code_e),
        .busy         (busy),
        .cmd_ok       (cmd_ok),
        .done         (done)
    );

    dll_wait_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_load_val),
        .dec      (tmr_dec),
        .zero     (tmr_zero)
    );

    dll_mode_shadow #(
        .MODE_INIT  (MODE_INIT),
        .EMODE_INIT (EMODE_INIT),
        .DLL_POS    (DLL_POS)
    ) u_shadow (
        .clk       (clk),
        .rst       (rst),
        .issue_rst (issue_rst),
        .issue_dis (issue_dis),
        .issue_en  (issue_en),
        .addr      (cmd_addr)
    );

    assign cmd_code = code_e;

    // Window counters for the timing assertions below
    localparam int MRS_CW = $clog2(PDN_LOCK + 2);
    localparam int EN_CW  = $clog2(LOCK_CYC + 2);
    localparam logic [MRS_CW-1:0] MRS_SAT = MRS_CW'(PDN_LOCK + 1);
    localparam logic [EN_CW-1:0]  EN_SAT  = EN_CW'(LOCK_CYC + 1);

    logic [MRS_CW-1:0] since_mrs;
    logic [EN_CW-1:0]  since_en;
    logic              mrs_seen;
    logic              en_seen;

    assign mrs_seen = cmd_valid && (cmd_code == 2'd1);
    assign en_seen  = cmd_valid && (cmd_code == 2'd2) && cmd_addr[DLL_POS];

    always_ff @(posedge clk) begin
        if (rst) begin
            since_mrs <= MRS_SAT;
            since_en  <= EN_SAT;
        end else begin
            if (mrs_seen) begin
                since_mrs <= MRS_CW'(1);
            end else if (since_mrs != MRS_SAT) begin
                since_mrs <= since_mrs + 1'b1;
            end
            if (en_seen) begin
                since_en <= EN_CW'(1);
            end else if (since_en != EN_SAT) begin
                since_en <= since_en + 1'b1;
            end
        end
    end

    // R1: test-mode bit stays low on every command
    assert_test_bit_low_R1: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !cmd_addr[7]);

    // R2: a mode-register command carries the reset bit
    assert_reset_bit_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 2'd1) |-> cmd_addr[8]);

    // R4: no power-down inside the window after the reset command
    assert_pd_lockout_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 2'd3) |-> (since_mrs > MRS_CW'(PDN_LOCK)));

    // R6: nothing is issued during the DLL lock time
    assert_lock_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (since_en > EN_CW'(LOCK_CYC)));

    // R8: done marks the rising edge of cmd_ok
    assert_done_edge_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (cmd_ok && !$past(cmd_ok)));

    // R8: done never lasts two cycles
    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: tb/test_dll_cmd_seq.sv
`timescale 1ns/1ps
module test_dll_cmd_seq;

    localparam int          PDN_LOCK   = 10;
    localparam int          LOCK_CYC   = 300;
    localparam int          DLL_POS    = 6;
    localparam logic [11:0] MODE_INIT  = 12'hCA5;
    localparam logic [11:0] EMODE_INIT = 12'h0C4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_dll_rst = 1'b0;
    logic        req_freq_chg = 1'b0;
    logic        clk_stable = 1'b0;
    logic        pd_req = 1'b0;
    logic        cmd_valid;
    logic [1:0]  cmd_code;
    logic [11:0] cmd_addr;
    logic        busy;
    logic        cmd_ok;
    logic        done;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dll_cmd_seq #(
        .PDN_LOCK   (PDN_LOCK),
        .LOCK_CYC   (LOCK_CYC),
        .DLL_POS    (DLL_POS),
        .MODE_INIT  (MODE_INIT),
        .EMODE_INIT (EMODE_INIT)
    ) i_dll_cmd_seq (
        .clk          (clk),
        .rst          (rst),
        .req_dll_rst  (req_dll_rst),
        .req_freq_chg (req_freq_chg),
        .clk_stable   (clk_stable),
        .pd_req       (pd_req),
        .cmd_valid    (cmd_valid),
        .cmd_code     (cmd_code),
        .cmd_addr     (cmd_addr),
        .busy         (busy),
        .cmd_ok       (cmd_ok),
        .done         (done)
    );

    function automatic logic [11:0] exp_mrs_addr();
        logic [11:0] a;
        a = MODE_INIT;
        a[8] = 1'b1;
        a[7] = 1'b0;
        return a;
    endfunction

    function automatic logic [11:0] exp_emr_addr(input logic en);
        logic [11:0] a;
        a = EMODE_INIT;
        a[7] = 1'b0;
        a[DLL_POS] = en;
        return a;
    endfunction

    task automatic check(input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic expect_cmd(input string rq, input logic [1:0] code, input logic [11:0] addr);
        check(rq, "strobe", {31'd0, cmd_valid}, 32'd1);
        check(rq, "code", {30'd0, cmd_code}, {30'd0, code});
        check(rq, "addr", {20'd0, cmd_addr}, {20'd0, addr});
        check("R1", "addr bit7", {31'd0, cmd_addr[7]}, 32'd0);
    endtask

    task automatic expect_idle(input string rq, input logic exp_done);
        check(rq, "idle strobe", {31'd0, cmd_valid}, 32'd0);
        check(rq, "idle busy", {31'd0, busy}, 32'd0);
        check(rq, "idle cmd_ok", {31'd0, cmd_ok}, 32'd1);
        check("R8", "done", {31'd0, done}, {31'd0, exp_done});
    endtask

    task automatic clear_reqs();
        req_dll_rst  = 1'b0;
        req_freq_chg = 1'b0;
        pd_req       = 1'b0;
    endtask

    // Reset path: optional simultaneous requests, pd_req hold, busy noise
    task automatic do_reset_seq(input bit with_freq, input bit with_pd,
                                input bit pd_hold, input bit noise);
        bit viol;
        int pick;
        req_dll_rst  = 1'b1;
        req_freq_chg = with_freq;
        pd_req       = with_pd;
        @(negedge clk);
        clear_reqs();
        expect_cmd((with_freq || with_pd) ? "R9" : "R2", 2'd1, exp_mrs_addr());
        pd_req = pd_hold;
        viol = 1'b0;
        pick = $urandom_range(PDN_LOCK, 1);
        for (int k = 1; k <= PDN_LOCK; k++) begin
            @(negedge clk);
            if (cmd_valid || !busy || cmd_ok) viol = 1'b1;
            if (noise && k == pick) begin
                req_dll_rst  = 1'b1;
                req_freq_chg = 1'b1;
            end else begin
                req_dll_rst  = 1'b0;
                req_freq_chg = 1'b0;
            end
        end
        check("R4", "quiet lockout window", {31'd0, viol}, 32'd0);
        @(negedge clk);
        req_dll_rst  = 1'b0;
        req_freq_chg = 1'b0;
        expect_idle("R8", 1'b1);
        if (pd_hold) begin
            @(negedge clk);
            pd_req = 1'b0;
            expect_cmd("R4", 2'd3, 12'h000);
            @(negedge clk);
            expect_idle("R10", 1'b0);
        end else begin
            @(negedge clk);
            expect_idle("R7", 1'b0);
        end
    endtask

    // Frequency-change path
    task automatic do_freq_seq(input bit with_pd, input int delay, input bit noise);
        bit viol;
        int pick;
        clk_stable   = 1'b0;
        req_freq_chg = 1'b1;
        pd_req       = with_pd;
        @(negedge clk);
        clear_reqs();
        expect_cmd(with_pd ? "R9" : "R5", 2'd2, exp_emr_addr(1'b0));
        viol = 1'b0;
        for (int i = 0; i < delay; i++) begin
            @(negedge clk);
            if (cmd_valid || !busy) viol = 1'b1;
        end
        check("R5", "no strobe while clock unsettled", {31'd0, viol}, 32'd0);
        clk_stable = 1'b1;
        @(negedge clk);
        expect_cmd("R5", 2'd2, exp_emr_addr(1'b1));
        clk_stable = $urandom_range(1, 0);
        viol = 1'b0;
        pick = $urandom_range(LOCK_CYC, 1);
        for (int k = 1; k <= LOCK_CYC; k++) begin
            @(negedge clk);
            if (cmd_valid || !busy || cmd_ok) viol = 1'b1;
            if (noise && k == pick) begin
                req_dll_rst = 1'b1;
                pd_req      = 1'b1;
            end else begin
                req_dll_rst = 1'b0;
                pd_req      = 1'b0;
            end
        end
        check("R6", "lock window blocked", {31'd0, viol}, 32'd0);
        @(negedge clk);
        clear_reqs();
        expect_idle("R6", 1'b1);
        @(negedge clk);
        expect_idle("R7", 1'b0);
    endtask

    task automatic do_pd_idle();
        pd_req = 1'b1;
        @(negedge clk);
        pd_req = 1'b0;
        expect_cmd("R10", 2'd3, 12'h000);
        check("R10", "busy during pd", {31'd0, busy}, 32'd1);
        @(negedge clk);
        expect_idle("R10", 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd41));
        rst = 1'b1;
        repeat (3) @(negedge clk);
        expect_idle("R11", 1'b0);
        rst = 1'b0;
        @(negedge clk);
        expect_idle("R11", 1'b0);

        // Directed corner cases
        do_reset_seq(1'b0, 1'b0, 1'b1, 1'b0);
        do_reset_seq(1'b0, 1'b0, 1'b0, 1'b1);
        // R3: repeated reset command carries the same bits again
        do_reset_seq(1'b1, 1'b1, 1'b0, 1'b0);
        do_pd_idle();
        do_freq_seq(1'b1, 1, 1'b1);
        do_freq_seq(1'b0, 17, 1'b0);

        // R11: reset in the middle of the clock wait
        clk_stable   = 1'b0;
        req_freq_chg = 1'b1;
        @(negedge clk);
        req_freq_chg = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R11", "busy before reset", {31'd0, busy}, 32'd1);
        rst = 1'b1;
        @(negedge clk);
        expect_idle("R11", 1'b0);
        rst = 1'b0;
        @(negedge clk);
        expect_idle("R11", 1'b0);
        do_freq_seq(1'b0, 3, 1'b0);

        // Random mix
        for (int it = 0; it < 20; it++) begin
            int op;
            op = $urandom_range(2, 0);
            repeat ($urandom_range(3, 0)) @(negedge clk);
            if (op == 0) begin
                do_reset_seq(1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
                             1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
            end else if (op == 1) begin
                do_freq_seq(1'($urandom_range(1, 0)), $urandom_range(20, 1),
                            1'($urandom_range(1, 0)));
            end else begin
                do_pd_idle();
            end
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule